// File: doc/BRIEF.md
# CTS Change Interrupt Cell with Transition-Armed Clear

This block is the modem-status interrupt bit of a serial port, limited to the clear-to-send line. The CTS input is brought into the UART clock domain through a synchronizer. Any change of the synchronized level, rising or falling, raises a raw interrupt status bit. A mask input gates that bit onto a masked interrupt output. The mask never alters the raw status.

Software clears the status through a write-only clear register. A write does not clear the status directly. Bit 1 of the written word is loaded into a hidden latch, and the status drops only when that latch goes from 0 to 1. Hardware returns the latch to 0 once the status is 0.

If a clear and a new CTS change reach the status in the same cycle, the change wins. The status stays set and the latch stays at 1. In that state a further write of 1 is not a transition and has no effect. Driver code therefore writes 0 to bit 1 and then writes 1, with at least one clock between the two writes.

Top module: `cts_irq_cell`

## Requirements
- R1: A rising edge of `cts_in` sets `raw_irq`. If `cts_in` changes before clock edge k, `raw_irq` reads 1 after edge k+2 (two synchronizer flops, then edge detection).
- R2: A falling edge of `cts_in` sets `raw_irq`, with the same latency as R1.
- R3: If `wr_en` is high with `wr_data[1]`=1 while the hidden latch is 0, and no CTS change is being detected, `raw_irq` is 0 after that clock edge.
- R4: A write of `wr_data[1]`=1 while the hidden latch is already 1 leaves `raw_irq` unchanged.
- R5: While `raw_irq` is 0 and no write occurs, hardware returns the latch to 0 on the next edge. A later write of 1 then clears a newly set status.
- R6: When a clear write and a detected CTS change land on the same edge, `raw_irq` stays 1 and the latch stays at 1.
- R7: A write with `wr_data[1]`=0 loads 0 into the latch, so a following write of 1 (one or more clocks later) clears the status.
- R8: Bits of `wr_data` other than bit 1 have no effect. A write with bit 1 at 0 never changes `raw_irq`.
- R9: `masked_irq` equals `raw_irq` AND `irq_mask`. Changing `irq_mask` never changes `raw_irq`.
- R10: While `rst_n` is low, and in the first cycle after it rises, `raw_irq` and `masked_irq` are 0, whatever level `cts_in` has.
- R11: When `wr_en` is low, `wr_data` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_in | input | 1 | Asynchronous clear-to-send line |
| wr_en | input | 1 | Write strobe for the clear register |
| wr_data | input | DATA_W | Clear register write data; only bit 1 is used |
| irq_mask | input | 1 | Interrupt enable for the masked output |
| raw_irq | output | 1 | Raw CTS-change interrupt status |
| masked_irq | output | 1 | Status gated by `irq_mask` |

## Verification
Several rules are checked by assertions on every cycle:
- set-over-clear priority at the status register;
- hold of the status when no event occurs;
- latch loading on a write;
- hardware release of the latch;
- the latch sticking at 1 while the status is set;
- the inertness of writes that leave bit 1 at 0.

Other properties need a sequence of events, and only the bench scenarios can show them:
- the three-edge latency from a CTS change to the status;
- the lock-up after a lost collision;
- recovery through the write-0-then-1 sequence;
- quiet behaviour across reset with CTS held high.

// File: rtl/cts_irq_pkg.sv
// Shared types for the CTS change interrupt cell.
// Assumes: nothing beyond a single clock domain after the synchronizer.
package cts_irq_pkg;

    // Events that can act on the status bit in one cycle.
    typedef struct packed {
        logic set;   // CTS change detected
        logic clr;   // 0->1 transition of the clear latch
    } stat_evt_t;

endpackage

// File: rtl/cts_edge_det.sv
// Synchronizes the CTS line and flags any change of its synchronized level.
// Assumes: SYNC_STAGES >= 2; the reset clears every flop, so no edge is
// reported in the first cycle after reset.
module cts_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_i,
    output logic edge_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // Shift the asynchronous line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[LAST-1:0], cts_i};
    end

    // Keep the last synchronized level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    // A change of either polarity counts as an edge.
    always_comb edge_o = sync_q[LAST] ^ prev_q;

    // After the edge, the stored copy must match the level that changed.
    AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (prev_q == $past(sync_q[LAST]))); // R1

endmodule

// File: rtl/cts_clr_latch.sv
// Hidden interrupt-clear latch: loaded from the clear-register bit on a write,
// released by hardware while the status is 0. It produces the clear event on
// a 0->1 transition.
// Assumes: writes are single-cycle strobes in the clk domain.
module cts_clr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic bit_i,
    input  logic stat_i,
    output logic clr_o,
    output logic lat_o
);
    logic lat_q;

    // Write loads the bit; otherwise release the latch once the status is clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        lat_q <= 1'b0;
        else if (wr_en_i)  lat_q <= bit_i;
        else if (!stat_i)  lat_q <= 1'b0;
    end

    // A clear is requested only when a 1 is written over a 0.
    always_comb clr_o = wr_en_i & bit_i & ~lat_q;
    always_comb lat_o = lat_q;

    AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (lat_q == $past(bit_i))); // R7
    AST_LATCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !stat_i) |=> !lat_q); // R5
    AST_LATCH_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && stat_i && lat_q) |=> lat_q); // R6

endmodule

// File: rtl/cts_stat_reg.sv
// Raw interrupt status bit. A set event has priority over a clear event.
// Assumes: events are one-cycle pulses from the edge detector and clear latch.
module cts_stat_reg
    import cts_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  stat_evt_t evt_i,
    output logic      stat_o
);
    logic stat_q;

    // Set wins; clear applies only when no set arrives in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         stat_q <= 1'b0;
        else if (evt_i.set) stat_q <= 1'b1;
        else if (evt_i.clr) stat_q <= 1'b0;
    end

    always_comb stat_o = stat_q;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.set |=> stat_q); // R1
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.set && evt_i.clr) |=> stat_q); // R6
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.clr && !evt_i.set) |=> !stat_q); // R3
    AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i.clr && !evt_i.set) |=> $stable(stat_q)); // R4

endmodule

// File: rtl/cts_irq_cell.sv
// Top of the CTS change interrupt cell: synchronizer and edge detector, hidden
// clear latch, status register and mask gating.
// Assumes: one clock; wr_en/wr_data come from a register decoder already in
// this clock domain; irq_mask is a register bit held elsewhere.
module cts_irq_cell
    import cts_irq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CLR_BIT     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_mask,
    output logic              raw_irq,
    output logic              masked_irq
);
    localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'(1) << CLR_BIT;

    logic      edge_w;
    logic      clr_w;
    logic      lat_w;
    logic      stat_w;
    stat_evt_t evt_w;

    cts_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cts_i  (cts_in),
        .edge_o (edge_w)
    );

    cts_clr_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .bit_i   (wr_data[CLR_BIT]),
        .stat_i  (stat_w),
        .clr_o   (clr_w),
        .lat_o   (lat_w)
    );

    // Bundle the two status events for the register.
    always_comb begin
        evt_w.set = edge_w;
        evt_w.clr = clr_w;
    end

    cts_stat_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_w),
        .stat_o (stat_w)
    );

    // Drive the raw status and its masked copy.
    always_comb begin
        raw_irq    = stat_w;
        masked_irq = stat_w & irq_mask;
    end

    AST_IGNORED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_data & CLR_MASK) == '0) && !edge_w)
        |=> (raw_irq == $past(raw_irq))); // R8
    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lat_w && !edge_w) |=> (raw_irq == $past(raw_irq))); // R4

endmodule

// File: tb/sim_cts_irq_cell.sv
module sim_cts_irq_cell;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_mask = 1'b0;
    logic       raw_irq;
    logic       masked_irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R10";

    always #2.5 clk = ~clk;

    cts_irq_cell u0 (
        .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .wr_en(wr_en),
        .wr_data(wr_data), .irq_mask(irq_mask),
        .raw_irq(raw_irq), .masked_irq(masked_irq)
    );

    // Behavioural reference: a delay queue for CTS, plus status and latch.
    bit cts_hist[$] = '{0, 0, 0};
    bit m_stat = 0;
    bit m_lat = 0;

    always @(posedge clk) begin
        bit chg, clr, n_stat, n_lat;
        started <= 1;
        if (!rst_n) begin
            cts_hist = '{0, 0, 0};
            m_stat = 0;
            m_lat = 0;
        end else begin
            chg    = cts_hist[1] != cts_hist[2];
            clr    = wr_en && wr_data[1] && !m_lat;
            n_stat = chg ? 1'b1 : (clr ? 1'b0 : m_stat);
            n_lat  = wr_en ? wr_data[1] : (m_stat ? m_lat : 1'b0);
            m_stat = n_stat;
            m_lat  = n_lat;
            cts_hist.push_front(cts_in);
            void'(cts_hist.pop_back());
        end
    end

    task automatic chk(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare with the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk({cur_req, " raw"}, raw_irq, m_stat);
            chk({"R9 ", cur_req, " masked"}, masked_irq, m_stat & irq_mask);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R10: reset with CTS high, then the first cycle after release.
        cts_in = 1'b1;
        irq_mask = 1'b1;
        tick(3);
        chk("R10 in reset", raw_irq, 1'b0);
        rst_n = 1'b1;
        tick(1);
        chk("R10 first cycle", raw_irq, 1'b0);
        chk("R10 masked", masked_irq, 1'b0);

        // R1: the synchronized rising edge sets the status.
        cur_req = "R1";
        tick(2);
        chk("R1 rise sets", raw_irq, 1'b1);

        // R3: a clear write of 1 over a released latch.
        cur_req = "R3";
        wr(8'h02);
        chk("R3 cleared", raw_irq, 1'b0);

        // R5: the latch is released; a new falling edge can be cleared.
        cur_req = "R5";
        tick(3);
        // R2: a falling edge sets the status with the same latency as a rise.
        cur_req = "R2";
        cts_in = 1'b0;
        tick(2);
        chk("R2 not yet", raw_irq, 1'b0);
        tick(1);
        chk("R2 fall sets", raw_irq, 1'b1);
        cur_req = "R5";
        wr(8'h02);
        chk("R5 release allows clear", raw_irq, 1'b0);
        tick(2);

        // R11: data with the strobe low is ignored.
        cur_req = "R11";
        cts_in = 1'b1;
        tick(4);
        chk("R11 status set", raw_irq, 1'b1);
        wr_data = 8'h02;
        tick(2);
        wr_data = 8'h00;
        chk("R11 no strobe", raw_irq, 1'b1);

        // R9: the mask gates only the masked output.
        cur_req = "R9";
        irq_mask = 1'b0;
        tick(1);
        chk("R9 masked off", masked_irq, 1'b0);
        chk("R9 raw kept", raw_irq, 1'b1);
        irq_mask = 1'b1;
        tick(1);
        chk("R9 masked on", masked_irq, 1'b1);

        // R6: a clear write collides with a new CTS change.
        cur_req = "R6";
        cts_in = 1'b0;
        tick(2);
        wr(8'h02);
        chk("R6 set wins", raw_irq, 1'b1);
        tick(3);

        // R4: the latch is stuck at 1, so a second write of 1 does nothing.
        cur_req = "R4";
        wr(8'h02);
        chk("R4 no transition", raw_irq, 1'b1);
        tick(2);
        chk("R4 still set", raw_irq, 1'b1);

        // R8: bit 1 at 0 with other bits set leaves the status alone.
        cur_req = "R8";
        wr(8'hFD);
        chk("R8 other bits ignored", raw_irq, 1'b1);
        tick(2);

        // R7: bit 1 at 0 reloads the latch, so a write of 1 clears again.
        cur_req = "R7";
        wr(8'h02);
        chk("R7 cleared after 0 then 1", raw_irq, 1'b0);

        // R7: back-to-back recovery writes, 0 then 1 one cycle apart.
        cts_in = 1'b1;
        tick(3);
        cur_req = "R6";
        cts_in = 1'b0;
        tick(2);
        wr(8'h02);
        chk("R6 second collision", raw_irq, 1'b1);
        tick(2);
        cur_req = "R7";
        wr(8'h00);
        wr(8'h02);
        chk("R7 back-to-back recovery", raw_irq, 1'b0);
        tick(4);
        chk("R5 stays clear", raw_irq, 1'b0);

        finish_run();
    end
endmodule